// File: doc/BRIEF.md
# Quarter-Rate Quadrature Downconverter

This block turns a stream of real, signed ADC samples into complex baseband I and Q samples. The block expects the intermediate frequency to sit at one quarter of the sample rate, for example a 5 MHz tone sampled at 20 MSPS. At that ratio the cosine reference reduces to the repeating sequence +1, 0, -1, 0 and the sine reference to 0, +1, 0, -1. Each product is therefore the sample itself, its negation, or zero. No oscillator table and no multiplier are needed. A two-bit phase machine walks through four states and selects pass, negate or zero for each of the two arms.

Bandpass sampling folds an IF at (n ± 0.25)·Fs onto Fs/4. When the IF lies at (n − 0.25)·Fs, the folded spectrum is mirrored. The `spec_inv` input corrects this by negating the Q arm for the sample that arrives with it. Filtering and decimation are left to the stages that follow.

The phase machine has four states, PH0, PH1, PH2 and PH3. Reset places it in PH0. Each accepted sample (`in_valid` high) moves it one step: PH0→PH1, PH1→PH2, PH2→PH3 and PH3→PH0. In a cycle without a valid sample it stays where it is.

Top module: `qdc_quarter_ddc`

## Requirements
- R1: After reset, `out_valid` is 0, `out_i` and `out_q` are 0, and the next accepted sample is treated as phase 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise: a fixed latency of one clock.
- R3: With x the sign-extended sample, `out_i` is +x in phase 0, −x in phase 2, and 0 in phases 1 and 3.
- R4: With `spec_inv` = 0, `out_q` is 0 in phases 0 and 2, +x in phase 1 and −x in phase 3.
- R5: With `spec_inv` = 1, `out_q` is −x in phase 1 and +x in phase 3, and `out_i` is the same as with `spec_inv` = 0.
- R6: The phase advances by one, modulo 4, only on a cycle with `in_valid` high. Idle cycles leave the phase unchanged.
- R7: When `in_valid` is low, `out_i` and `out_q` keep their previous values, and the value on `in_sample` has no effect.
- R8: The outputs are 13 bits, two's complement. Negating the input −2048 gives +2048 with no overflow.
- R9: `spec_inv` is taken from the same cycle as the sample it applies to, so it may change between any two samples.
- R10: An ideal Fs/4 tone gives a constant `out_i` on phases 0 and 2 and a constant `out_q` on phases 1 and 3, with the sign set by the tone's phase and by `spec_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that marks an accepted sample |
| in_sample | input | 12 | ADC sample, two's complement |
| spec_inv | input | 1 | Negates the Q arm for a mirrored alias zone |
| out_valid | output | 1 | Strobe that marks new I/Q values |
| out_i | output | 13 | In-phase product, two's complement |
| out_q | output | 13 | Quadrature product, two's complement |

## Verification
The bench builds the block with its default 12-bit input width, which gives a 13-bit output. This makes the full-scale corner reachable: −2048 is negated in phase 2 on the I arm and in phase 3 on the Q arm, and must come out as +2048.

Random valid gaps test whether the phase machine holds through idle cycles. Random `spec_inv` flips test whether the mode is applied one sample at a time. A fixed-phase quarter-rate tone, run after a fresh reset, pins down the absolute phase alignment.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2,
        PH3 = 2'd3
    } qdc_phase_t;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_PASS = 2'd1,
        SEL_NEG  = 2'd2
    } qdc_sel_t;
endpackage

// File: rtl/qdc_phase_fsm.sv
module qdc_phase_fsm
    import qdc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    input  logic     inv,
    output qdc_sel_t sel_i,
    output qdc_sel_t sel_q
);
    qdc_phase_t state_q, state_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                PH0: state_d = PH1;
                PH1: state_d = PH2;
                PH2: state_d = PH3;
                PH3: state_d = PH0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH0;
        else        state_q <= state_d;
    end

    // selector outputs for the current sample
    always_comb begin
        sel_i = SEL_ZERO;
        sel_q = SEL_ZERO;
        unique case (state_q)
            PH0: begin
                sel_i = SEL_PASS;
                sel_q = SEL_ZERO;
            end
            PH1: begin
                sel_i = SEL_ZERO;
                sel_q = inv ? SEL_NEG : SEL_PASS;
            end
            PH2: begin
                sel_i = SEL_NEG;
                sel_q = SEL_ZERO;
            end
            PH3: begin
                sel_i = SEL_ZERO;
                sel_q = inv ? SEL_PASS : SEL_NEG;
            end
        endcase
    end
endmodule

// File: rtl/qdc_sign_sel.sv
module qdc_sign_sel
    import qdc_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  qdc_sel_t               sel,
    input  logic signed [IN_W-1:0] din,
    output logic signed [IN_W:0]   dout
);
    logic signed [IN_W:0] ext;
    assign ext = {din[IN_W-1], din};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (en) begin
            unique case (sel)
                SEL_PASS: dout <= ext;
                SEL_NEG:  dout <= -ext;
                default:  dout <= '0;
            endcase
        end
    end
endmodule

// File: rtl/qdc_quarter_ddc.sv
module qdc_quarter_ddc
    import qdc_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    input  logic                   spec_inv,
    output logic                   out_valid,
    output logic signed [IN_W:0]   out_i,
    output logic signed [IN_W:0]   out_q
);
    localparam int NARM = 2;

    qdc_sel_t sel_i, sel_q;
    qdc_sel_t arm_sel [NARM];
    logic signed [IN_W:0] arm_out [NARM];

    qdc_phase_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .inv   (spec_inv),
        .sel_i (sel_i),
        .sel_q (sel_q)
    );

    assign arm_sel[0] = sel_i;
    assign arm_sel[1] = sel_q;

    for (genvar g = 0; g < NARM; g++) begin : g_arm
        qdc_sign_sel #(.IN_W(IN_W)) u_arm (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .sel   (arm_sel[g]),
            .din   (in_sample),
            .dout  (arm_out[g])
        );
    end

    assign out_i = arm_out[0];
    assign out_q = arm_out[1];

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end
endmodule

// File: rtl/qdc_quarter_ddc_chk.sv
module qdc_quarter_ddc_chk #(
    parameter int IN_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic signed [IN_W-1:0] in_sample,
    input logic                   spec_inv,
    input logic                   out_valid,
    input logic signed [IN_W:0]   out_i,
    input logic signed [IN_W:0]   out_q
);
    logic [1:0] cnt;
    logic signed [IN_W:0] xe;
    assign xe = {in_sample[IN_W-1], in_sample};

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= 2'd0;
        else if (in_valid) cnt <= cnt + 2'd1;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(out_i) && $stable(out_q))); // R7
    AST_ONE_ARM_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_i == '0 || out_q == '0)); // R3
    AST_I_PHASE0: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && cnt == 2'd0) |=> out_i == $past(xe)); // R3
    AST_I_PHASE2: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && cnt == 2'd2) |=> out_i == -$past(xe)); // R8
    AST_Q_PHASE1: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && cnt == 2'd1) |=> out_q == ($past(spec_inv) ? -$past(xe) : $past(xe))); // R5
endmodule

bind qdc_quarter_ddc qdc_quarter_ddc_chk #(.IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .spec_inv  (spec_inv),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/tb_qdc_quarter_ddc.sv
module tb_qdc_quarter_ddc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [11:0] in_sample = '0;
    logic spec_inv = 1'b0;
    logic out_valid;
    logic signed [12:0] out_i, out_q;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;
    logic signed [12:0] last_i = '0, last_q = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qdc_quarter_ddc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .spec_inv(spec_inv), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic logic signed [12:0] exp_i(logic signed [11:0] x, int p);
        logic signed [12:0] e = {x[11], x};
        if (p == 0) return e;
        if (p == 2) return -e;
        return '0;
    endfunction

    function automatic logic signed [12:0] exp_q(logic signed [11:0] x, int p, logic inv);
        logic signed [12:0] e = {x[11], x};
        if (p == 1) return inv ? -e : e;
        if (p == 3) return inv ? e : -e;
        return '0;
    endfunction

    task automatic check(string req, logic signed [12:0] act, logic signed [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ph = 0; last_i = '0; last_q = '0;
        check("R1 valid", {12'd0, out_valid}, 13'sd0);
        check("R1 i", out_i, 13'sd0);
        check("R1 q", out_q, 13'sd0);
    endtask

    task automatic send(logic signed [11:0] x, logic inv, string req);
        in_valid = 1'b1; in_sample = x; spec_inv = inv;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check({req, " R2 valid"}, {12'd0, out_valid}, 13'sd1);
        check({req, " R3 i"}, out_i, exp_i(x, ph));
        check({req, (inv ? " R5 q" : " R4 q")}, out_q, exp_q(x, ph, inv));
        last_i = exp_i(x, ph); last_q = exp_q(x, ph, inv);
        ph = (ph + 1) % 4;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b0; in_sample = 12'($urandom); spec_inv = 1'($urandom);
            @(posedge clk); @(negedge clk);
            check("R2 idle valid", {12'd0, out_valid}, 13'sd0);
            check("R7 hold i", out_i, last_i);
            check("R7 hold q", out_q, last_q);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd42));
        @(negedge clk);
        do_reset();
        // R3 R4 directed full-scale and R8 negation of -2048
        send(-12'sd2048, 1'b0, "R8");
        send(-12'sd2048, 1'b0, "R8");
        send(-12'sd2048, 1'b0, "R8");
        send(-12'sd2048, 1'b0, "R8");
        send(12'sd2047, 1'b1, "R5");
        send(12'sd2047, 1'b1, "R5");
        send(12'sd2047, 1'b1, "R5");
        send(12'sd2047, 1'b1, "R5");
        // R6 phase held across idle gaps
        idle(3);
        send(12'sd100, 1'b0, "R6");
        idle(2);
        send(12'sd100, 1'b0, "R6");
        // R9 mode flipping every sample, random gaps
        for (int k = 0; k < 2000; k++) begin
            send(12'($urandom), 1'($urandom), "R9");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        // R10 ideal tone, cos phi = 0.6, sin phi = 0.8, amplitude 1000
        for (int m = 0; m < 2; m++) begin
            do_reset();
            for (int k = 0; k < 16; k++) begin
                logic signed [11:0] tone [4];
                tone[0] = 12'sd600; tone[1] = -12'sd800; tone[2] = -12'sd600; tone[3] = 12'sd800;
                in_valid = 1'b1; in_sample = tone[k % 4]; spec_inv = m[0];
                @(posedge clk); @(negedge clk);
                in_valid = 1'b0;
                if (k % 2 == 0) check("R10 tone i", out_i, 13'sd600);
                else            check("R10 tone q", out_q, m == 0 ? -13'sd800 : 13'sd800);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule